// File: doc/BRIEF.md
# Sixteen-bit ALU Slice with Short-Immediate Extension

This block is the arithmetic slice of a small 16-bit processor core. On each cycle where the issue logic raises `op_valid`, the slice decodes the instruction word, picks its second operand, computes an addition, a bitwise AND or a bitwise complement, and presents the registered result one clock later. The result comes with a write qualifier and the index of the destination register, which the register file uses for writeback.

The second operand is either the register value supplied on `src_b` or a 5-bit constant taken from the instruction. A single instruction bit makes that choice. The constant is widened to 16 bits as a two's-complement number. The slice also owns the condition-code register that the branch logic reads. This register is a one-hot negative/zero/positive triple. It reloads only from a value that is actually written back.

Top module: `alu16_slice`

## Requirements
- R1: The operation is taken from instruction bits [15:12]: 4'h1 is ADD, 4'h5 is AND, 4'h9 is NOT. Bits [11:9] name the destination and appear on `dst_idx` together with the result.
- R2: For ADD and AND, when instruction bit 5 is 0, the second operand is `src_b`, which holds the register named by bits [2:0]. Bits [4:3] are zero in this form.
- R3: For ADD and AND, when instruction bit 5 is 1, the second operand is bits [4:0] sign-extended to 16 bits: bit 4 is copied into bits [15:5].
- R4: ADD wraps modulo 2^16 and raises no overflow indication.
- R5: AND is bitwise. The immediate 5'h1F extends to 16'hFFFF, so AND with it returns `src_a` unchanged.
- R6: NOT returns the bitwise complement of `src_a` (the register named by bits [8:6]). Bits [5:0] have no effect on it.
- R7: A recognised operation accepted at a rising edge sets `result`, `dst_idx` and a one-cycle `result_we` pulse at that same edge. `result_we` is low after any edge where `op_valid` was low or the opcode was not one of the three.
- R8: `cond_code` is one-hot with P = 3'b001, Z = 3'b010 and N = 3'b100. Z is chosen when the written value is zero. Otherwise N is chosen when bit 15 is 1. P is chosen in all other cases.
- R9: `cond_code` loads only at an edge that produces a write. It holds its value otherwise, including for unrecognised opcodes. Reset gives `cond_code` = 3'b010, `result` = 0 and `result_we` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | The instruction and operands are valid this cycle |
| instr | input | 16 | Instruction word |
| src_a | input | 16 | Value of the register named by bits [8:6] |
| src_b | input | 16 | Value of the register named by bits [2:0] |
| result | output | 16 | Registered result |
| result_we | output | 1 | Result is to be written back (one-cycle pulse) |
| dst_idx | output | 3 | Destination register index for the write |
| cond_code | output | 3 | One-hot N/Z/P condition code |

## Verification
The result, the destination index, the write pulse and the condition code all come from the rising edge at which the operation is offered. They are therefore due exactly one clock after the stimulus, and no output has a longer delay. The bench applies inputs on the falling edge and updates its behavioural model at the next rising edge. On the following falling edge it compares all four outputs. Idle cycles and unrecognised opcodes go through the same per-cycle comparison. This shows the write pulse dropping and the condition code holding in the cycle where either would otherwise change.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int DATA_W  = 16;
    localparam int IMM_W   = 5;
    localparam int REG_W   = 3;
    localparam int OPC_W   = 4;
    localparam int OPC_LSB = DATA_W - OPC_W;
    localparam int DST_LSB = OPC_LSB - REG_W;
    localparam int SEL_BIT = IMM_W;
    localparam int CC_W    = 3;

    typedef enum logic [OPC_W-1:0] {
        OPC_ADD = 4'h1,
        OPC_AND = 4'h5,
        OPC_NOT = 4'h9
    } opc_e;

    typedef enum logic [1:0] {
        FN_NONE,
        FN_ADD,
        FN_AND,
        FN_NOT
    } fn_e;

    typedef struct packed {
        fn_e              fn;
        logic [REG_W-1:0] dst;
        logic             use_imm;
    } dec_t;

    typedef logic [CC_W-1:0] cc_t;

    localparam cc_t CC_POS  = 3'b001;
    localparam cc_t CC_ZERO = 3'b010;
    localparam cc_t CC_NEG  = 3'b100;

    function automatic cc_t classify(input logic [DATA_W-1:0] v);
        if (v == '0)
            return CC_ZERO;
        else if (v[DATA_W-1])
            return CC_NEG;
        else
            return CC_POS;
    endfunction

endpackage

// File: rtl/alu16_decode.sv
module alu16_decode
    import alu16_pkg::*;
(
    input  logic [DATA_W-1:0] instr,
    output dec_t              dec
);
    always_comb begin
        dec.dst     = instr[DST_LSB +: REG_W];
        dec.use_imm = instr[SEL_BIT];
        case (instr[OPC_LSB +: OPC_W])
            OPC_ADD: dec.fn = FN_ADD;
            OPC_AND: dec.fn = FN_AND;
            OPC_NOT: dec.fn = FN_NOT;
            default: dec.fn = FN_NONE;
        endcase
    end
endmodule

// File: rtl/alu16_opsel.sv
module alu16_opsel #(
    parameter int W     = 16,
    parameter int IMM_N = 5
) (
    input  logic [W-1:0] instr,
    input  logic         use_imm,
    input  logic [W-1:0] reg_val,
    output logic [W-1:0] opnd
);
    localparam int EXT_N = W - IMM_N;

    logic [W-1:0] imm_ext;

    generate
        if (EXT_N > 0) begin : g_ext
            assign imm_ext = {{EXT_N{instr[IMM_N-1]}}, instr[IMM_N-1:0]};
        end else begin : g_noext
            assign imm_ext = instr[W-1:0];
        end
    endgenerate

    assign opnd = use_imm ? imm_ext : reg_val;
endmodule

// File: rtl/alu16_exec.sv
module alu16_exec
    import alu16_pkg::*;
(
    input  fn_e               fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              writes
);
    always_comb begin
        writes = 1'b1;
        case (fn)
            FN_ADD:  y = a + b;
            FN_AND:  y = a & b;
            FN_NOT:  y = ~a;
            default: begin
                y      = '0;
                writes = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu16_ccreg.sv
module alu16_ccreg
    import alu16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] value,
    output cc_t               cc
);
    always_ff @(posedge clk) begin
        if (rst)
            cc <= CC_ZERO;
        else if (load)
            cc <= classify(value);
    end
endmodule

// File: rtl/alu16_slice.sv
module alu16_slice
    import alu16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [15:0]       instr,
    input  logic [15:0]       src_a,
    input  logic [15:0]       src_b,
    output logic [15:0]       result,
    output logic              result_we,
    output logic [2:0]        dst_idx,
    output logic [2:0]        cond_code
);
    dec_t              dec;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] alu_y;
    logic              alu_writes;
    logic              do_write;

    alu16_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    alu16_opsel #(.W(DATA_W), .IMM_N(IMM_W)) u_sel (
        .instr   (instr),
        .use_imm (dec.use_imm),
        .reg_val (src_b),
        .opnd    (opnd_b)
    );

    alu16_exec u_exec (
        .fn     (dec.fn),
        .a      (src_a),
        .b      (opnd_b),
        .y      (alu_y),
        .writes (alu_writes)
    );

    assign do_write = op_valid && alu_writes;

    alu16_ccreg u_cc (
        .clk   (clk),
        .rst   (rst),
        .load  (do_write),
        .value (alu_y),
        .cc    (cond_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            result_we <= 1'b0;
            dst_idx   <= '0;
        end else begin
            result_we <= do_write;
            if (do_write) begin
                result  <= alu_y;
                dst_idx <= dec.dst;
            end
        end
    end
endmodule

// File: rtl/alu16_slice_chk.sv
module alu16_slice_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [15:0] instr,
    input logic [15:0] src_a,
    input logic [15:0] src_b,
    input logic [15:0] result,
    input logic        result_we,
    input logic [2:0]  cond_code
);
    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(cond_code) == 1);

    a_r8_zero: assert property (@(posedge clk) disable iff (rst)
        (result_we && result == 16'h0000) |-> cond_code == 3'b010);

    a_r8_neg: assert property (@(posedge clk) disable iff (rst)
        (result_we && result[15]) |-> cond_code == 3'b100);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !result_we |-> $stable(cond_code));

    a_r7_we_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (op_valid == 1'b0) |=> !result_we);

    a_r4_add_reg: assert property (@(posedge clk) disable iff (rst)
        (op_valid && instr[15:12] == 4'h1 && !instr[5])
        |=> result == 16'($past(src_a) + $past(src_b)));

    a_r6_not: assert property (@(posedge clk) disable iff (rst)
        (op_valid && instr[15:12] == 4'h9) |=> result == ~$past(src_a));
endmodule

bind alu16_slice alu16_slice_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .instr     (instr),
    .src_a     (src_a),
    .src_b     (src_b),
    .result    (result),
    .result_we (result_we),
    .cond_code (cond_code)
);

// File: tb/sim_alu16_slice.sv
module sim_alu16_slice;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] src_a = '0;
    logic [15:0] src_b = '0;
    logic [15:0] result;
    logic        result_we;
    logic [2:0]  dst_idx;
    logic [2:0]  cond_code;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_res = '0;
    logic        m_we  = 1'b0;
    logic [2:0]  m_dst = '0;
    logic [2:0]  m_cc  = 3'b010;

    always #(PERIOD/2) clk = ~clk;

    alu16_slice u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .result(result),
        .result_we(result_we), .dst_idx(dst_idx), .cond_code(cond_code)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] imm_value(input logic [15:0] ins);
        int v;
        v = int'(ins[4:0]);
        if (v >= 16) v = v - 32;
        return 16'(v);
    endfunction

    task automatic model_edge(input logic v, input logic [15:0] ins,
                              input logic [15:0] a, input logic [15:0] b);
        logic [15:0] opb;
        logic [15:0] y;
        logic        hit;
        int          sum;
        opb = ins[5] ? imm_value(ins) : b;
        hit = 1'b1;
        y   = '0;
        case (ins[15:12])
            4'h1: begin sum = (int'(a) + int'(opb)) % 65536; y = 16'(sum); end
            4'h5: y = a & opb;
            4'h9: y = a ^ 16'hFFFF;
            default: hit = 1'b0;
        endcase
        m_we = v && hit;
        if (m_we) begin
            m_res = y;
            m_dst = ins[11:9];
            if (y == 0)       m_cc = 3'b010;
            else if (y >= 16'h8000) m_cc = 3'b100;
            else              m_cc = 3'b001;
        end
    endtask

    task automatic step(input string tag, input logic v, input logic [15:0] ins,
                        input logic [15:0] a, input logic [15:0] b);
        op_valid = v; instr = ins; src_a = a; src_b = b;
        @(posedge clk);
        model_edge(v, ins, a, b);
        @(negedge clk);
        check({tag, " result"}, result, m_res);
        check("R7 result_we", {15'b0, result_we}, {15'b0, m_we});
        check("R1 dst_idx", {13'b0, dst_idx}, {13'b0, m_dst});
        check(m_we ? "R8 cond_code" : "R9 cond_code hold", {13'b0, cond_code}, {13'b0, m_cc});
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset result", result, 16'h0000);
        check("R9 reset we", {15'b0, result_we}, 16'h0000);
        check("R9 reset cc", {13'b0, cond_code}, 16'h0002);
        rst = 1'b0;

        // R2: ADD register form, dst 3
        step("R2 add reg", 1'b1, 16'h1642, 16'h0010, 16'h0025);
        // R3: ADD immediate +7
        step("R3 add imm pos", 1'b1, 16'h1A27, 16'h0100, 16'hDEAD);
        // R3: ADD immediate -16 gives negative result
        step("R3 add imm neg", 1'b1, 16'h1230, 16'h0005, 16'h0000);
        // R4: wrap 0xFFFF + 1 = 0 -> Z
        step("R4 add wrap", 1'b1, 16'h1021, 16'hFFFF, 16'h0000);
        // R4: large register wrap
        step("R4 add wrap reg", 1'b1, 16'h1E01, 16'h8000, 16'h8001);
        // R5: AND register form
        step("R5 and reg", 1'b1, 16'h5403, 16'hF0F0, 16'h3C3C);
        // R5: AND with 0x1F passes src_a through
        step("R5 and all-ones imm", 1'b1, 16'h563F, 16'h9ABC, 16'h0000);
        // R5: AND with +15
        step("R5 and imm pos", 1'b1, 16'h582F, 16'h9ABC, 16'hFFFF);
        // R6: NOT, low bits set but ignored
        step("R6 not", 1'b1, 16'h9E3F, 16'h00FF, 16'h1234);
        step("R6 not to zero", 1'b1, 16'h9000, 16'hFFFF, 16'h0000);
        // R9/R7: idle cycle holds cc, drops we
        step("R7 idle", 1'b0, 16'h1021, 16'h0001, 16'h0000);
        // R9: unrecognised opcode holds cc
        step("R9 bad opcode", 1'b1, 16'h2021, 16'h8000, 16'h0000);
        step("R1 positive", 1'b1, 16'h1C21, 16'h0001, 16'h0000);

        for (int i = 0; i < 400; i++) begin
            logic [15:0] ins;
            logic [3:0]  pick;
            ins  = 16'($urandom);
            pick = 4'($urandom_range(0, 4));
            case (pick)
                4'd0: ins[15:12] = 4'h1;
                4'd1: ins[15:12] = 4'h5;
                4'd2: ins[15:12] = 4'h9;
                default: ;
            endcase
            if (!ins[5]) ins[4:3] = 2'b00;
            step("R1 random", ($urandom_range(0, 7) != 0), ins,
                 16'($urandom), 16'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule